// File: doc/BRIEF.md
# Upstream Request Bus-Master Gate

This block sits on the upstream request path of a PCI Express bridge port, between the secondary-side request source and the primary-side request sink. It holds a small command register with three enable bits. Every request that arrives from the secondary side is handled according to the bus-master enable bit that is in force at the moment the request is accepted.

With bus mastering enabled, memory requests, I/O requests and messages leave the block unchanged. With bus mastering disabled, they become invalid cycles. Write-type traffic is turned into a memory write to a fixed sink address with every byte-lane enable cleared, so that nothing is stored. This covers message-signalled interrupts, which travel as memory writes, so they are blocked too. Read-type traffic is turned into a memory read of the same sink address. Once that redirected read has been taken downstream, a single Unsupported Request completion with the original tag goes back to the requester on a return channel. Completions are never gated.

All three interfaces use valid/ready handshakes. A single output register carries both redirected and pass-through traffic, so requests leave in the order they arrived.

Top module: `upreq_master_gate`

## Requirements
- R1: After reset the command register reads 0. Bits 2 (bus-master enable), 1 (memory enable) and 0 (I/O enable) take the value written, and the new value is visible on `cfg_rd_data` after the write edge.
- R2: Bit 3 of the command register always reads 0. Writing it has no effect on any bit.
- R3: With bus-master enable at 1, a request of kind memory read (0), memory write (1), I/O read (2), I/O write (3) or message (4) appears on the output one cycle after acceptance with kind, address, byte enables and tag unchanged, and no return completion is produced.
- R4: With bus-master enable at 0, a memory write, I/O write or message leaves as a memory write (1) to address 0x000C_0000 with byte enables 0 and its tag kept, and no return completion is produced.
- R5: With bus-master enable at 0, a memory read or I/O read leaves as a memory read (0) to address 0x000C_0000 with its tag kept. Exactly one return completion follows, carrying that tag and status code 1 (Unsupported Request).
- R6: The return completion for a redirected read is raised only in the cycle after that redirected read is accepted on the output, and never while it is still held by backpressure.
- R7: Completions (kind 5) pass unchanged whatever the value of bus-master enable.
- R8: Bus-master enable is sampled when a request is accepted. A register write in the same cycle, or while the request waits at the output, does not change how that request is handled.
- R9: While the output is stalled, the presented request stays valid and its fields stay stable, `in_ready` is low, and requests leave in arrival order.
- R10: While a return completion is still pending, a second redirected read is held at the output and not presented until the pending completion has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Command register write strobe |
| cfg_wr_data | input | 4 | Command register write value |
| cfg_rd_data | output | 4 | Command register read value |
| in_valid | input | 1 | Secondary-side request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_kind | input | 3 | Request kind: 0 MRd, 1 MWr, 2 IORd, 3 IOWr, 4 Msg, 5 Cpl |
| in_addr | input | ADDR_W | Request address |
| in_be | input | BE_W | Request byte-lane enables |
| in_tag | input | TAG_W | Request tag |
| out_valid | output | 1 | Primary-side request valid |
| out_ready | input | 1 | Primary side takes the request |
| out_kind | output | 3 | Outgoing kind |
| out_addr | output | ADDR_W | Outgoing address |
| out_be | output | BE_W | Outgoing byte-lane enables |
| out_tag | output | TAG_W | Outgoing tag |
| ret_valid | output | 1 | Unsupported Request completion valid |
| ret_ready | input | 1 | Requester takes the completion |
| ret_tag | output | TAG_W | Tag of the refused read |
| ret_status | output | 3 | Completion status, 1 = Unsupported Request |

## Verification
On every cycle the assertions check the shape of redirected writes and of passed completions in the cycle after acceptance. They also check that a raised return completion was preceded by an accepted redirected read, that the pending completion slot is never overwritten, that a stalled output holds still, and that register writes land. Only the bench's scenarios can show the full end-to-end picture. That covers the ignored reserved bit, unchanged pass-through of every kind, exactly one completion per refused read, the enable sampled at acceptance rather than at departure, and the arrival order kept under backpressure.

// File: rtl/upreq_pkg.sv
package upreq_pkg;
  localparam logic [2:0] K_MRD  = 3'd0;
  localparam logic [2:0] K_MWR  = 3'd1;
  localparam logic [2:0] K_IORD = 3'd2;
  localparam logic [2:0] K_IOWR = 3'd3;
  localparam logic [2:0] K_MSG  = 3'd4;
  localparam logic [2:0] K_CPL  = 3'd5;

  localparam logic [2:0] ST_UR  = 3'd1;

  // read-type requests get a refusal completion when gated
  function automatic logic f_is_read(input logic [2:0] k);
    return (k == K_MRD) || (k == K_IORD);
  endfunction

  // write-type requests (messages carry interrupts as writes)
  function automatic logic f_is_write(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR) || (k == K_MSG);
  endfunction

  // request that bus-master enable governs
  function automatic logic f_is_gated(input logic [2:0] k);
    return f_is_read(k) || f_is_write(k);
  endfunction
endpackage

// File: rtl/upreq_cmd_reg.sv
module upreq_cmd_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  output logic       bme
);
  localparam int BIT_IO  = 0;
  localparam int BIT_MEM = 1;
  localparam int BIT_BM  = 2;
  localparam int NBITS   = 3;

  logic [NBITS-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[NBITS-1:0];
  end

  // bit 3 is read-only zero
  assign rd_data = {1'b0, en_q[BIT_BM], en_q[BIT_MEM], en_q[BIT_IO]};
  assign bme     = en_q[BIT_BM];

  // R1
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[2:0] == $past(wr_data[2:0]));
endmodule

// File: rtl/upreq_redirect.sv
module upreq_redirect
  import upreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 32'h000C_0000
) (
  input  logic              bme,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              refuse_o
);
  logic gated, kill_wr;

  assign gated    = !bme && f_is_gated(kind_i);
  assign kill_wr  = gated && f_is_write(kind_i);
  assign refuse_o = gated && f_is_read(kind_i);

  always_comb begin
    kind_o = kind_i;
    addr_o = addr_i;
    if (gated) begin
      kind_o = refuse_o ? K_MRD : K_MWR;
      addr_o = SINK_ADDR;
    end
  end

  // each byte lane is cleared on a gated write
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be_o[g] = be_i[g] & ~kill_wr;
  end
endmodule

// File: rtl/upreq_stage.sv
module upreq_stage #(
  parameter int PW = 47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [PW-1:0] ld_data,
  input  logic          ld_refuse,
  input  logic          ret_busy,
  output logic          can_load,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data,
  output logic          out_refuse,
  output logic          fire
);
  logic          v_q;
  logic          ref_q;
  logic [PW-1:0] d_q;

  // a refused read waits while an earlier refusal is still pending
  assign out_valid  = v_q && !(ref_q && ret_busy);
  assign fire       = out_valid && out_ready;
  assign can_load   = !v_q || fire;
  assign out_data   = d_q;
  assign out_refuse = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      ref_q <= 1'b0;
      d_q   <= '0;
    end else if (can_load) begin
      v_q <= ld_valid;
      if (ld_valid) begin
        d_q   <= ld_data;
        ref_q <= ld_refuse;
      end
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> v_q && $stable(out_data));
endmodule

// File: rtl/upreq_ur_ret.sv
module upreq_ur_ret #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic             ret_valid,
  input  logic             ret_ready,
  output logic [TAG_W-1:0] ret_tag
);
  logic             p_q;
  logic [TAG_W-1:0] t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      t_q <= '0;
    end else if (set_en) begin
      p_q <= 1'b1;
      t_q <= set_tag;
    end else if (ret_ready) begin
      p_q <= 1'b0;
    end
  end

  assign ret_valid = p_q;
  assign ret_tag   = t_q;

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !p_q);
endmodule

// File: rtl/upreq_master_gate.sv
module upreq_master_gate
  import upreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int TAG_W  = 8,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [3:0]        cfg_wr_data,
  output logic [3:0]        cfg_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BE_W-1:0]   out_be,
  output logic [TAG_W-1:0]  out_tag,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [2:0]        ret_status
);
  localparam int PW = 3 + ADDR_W + BE_W + TAG_W;

  logic              bme;
  logic [2:0]        rk;
  logic [ADDR_W-1:0] ra;
  logic [BE_W-1:0]   rb;
  logic              refuse;
  logic [PW-1:0]     sd;
  logic              sref, sfire;
  logic              in_fire, refuse_fire;

  upreq_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .bme(bme)
  );

  upreq_redirect #(.ADDR_W(ADDR_W), .BE_W(BE_W), .SINK_ADDR(SINK_ADDR)) u_redir (
    .bme(bme), .kind_i(in_kind), .addr_i(in_addr), .be_i(in_be),
    .kind_o(rk), .addr_o(ra), .be_o(rb), .refuse_o(refuse)
  );

  upreq_stage #(.PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n), .ld_valid(in_valid), .ld_data({rk, ra, rb, in_tag}),
    .ld_refuse(refuse), .ret_busy(ret_valid), .can_load(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(sd),
    .out_refuse(sref), .fire(sfire)
  );

  assign {out_kind, out_addr, out_be, out_tag} = sd;
  assign in_fire     = in_valid && in_ready;
  assign refuse_fire = sfire && sref;

  upreq_ur_ret #(.TAG_W(TAG_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .set_en(refuse_fire), .set_tag(out_tag),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_tag(ret_tag)
  );

  assign ret_status = ST_UR;

  // R4
  redir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !bme && f_is_write(in_kind) |=>
      out_valid && out_kind == K_MWR && out_addr == SINK_ADDR && out_be == '0);

  // R7
  cpl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_kind == K_CPL |=>
      out_valid && out_kind == K_CPL && out_addr == $past(in_addr) && out_tag == $past(in_tag));

  // R6
  ret_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_valid) |-> $past(out_valid && out_ready && out_kind == K_MRD));

  // R5
  ret_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_fire |=> ret_valid && ret_tag == $past(out_tag));
endmodule

// File: tb/tb_upreq_master_gate.sv
module tb_upreq_master_gate;
  localparam logic [31:0] SINK = 32'h000C_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_data = '0;
  logic [3:0]  cfg_rd_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [31:0] in_addr = '0;
  logic [3:0]  in_be = '0;
  logic [7:0]  in_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_kind;
  logic [31:0] out_addr;
  logic [3:0]  out_be;
  logic [7:0]  out_tag;
  logic        ret_valid;
  logic        ret_ready = 1'b1;
  logic [7:0]  ret_tag;
  logic [2:0]  ret_status;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  upreq_master_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_be(in_be), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_be(out_be), .out_tag(out_tag),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_tag(ret_tag),
    .ret_status(ret_status)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0; #1;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [2:0] k, input logic [31:0] a,
                      input logic [3:0] b, input logic [7:0] t);
    in_valid = 1'b1; in_kind = k; in_addr = a; in_be = b; in_tag = t; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; #1;
  endtask

  task automatic expect_out(input string req, input logic [2:0] k,
                            input logic [31:0] a, input logic [3:0] b, input logic [7:0] t);
    chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(req, "out_kind", {29'd0, out_kind}, {29'd0, k});
    chk(req, "out_addr", out_addr, a);
    chk(req, "out_be", {28'd0, out_be}, {28'd0, b});
    chk(req, "out_tag", {24'd0, out_tag}, {24'd0, t});
  endtask

  task automatic t_reset;
    chk("R1", "cfg after reset", {28'd0, cfg_rd_data}, 32'd0);
    chk("R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R5", "ret_valid after reset", {31'd0, ret_valid}, 32'd0);
    chk("R9", "in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_cmd;
    cfg_write(4'hF);
    chk("R2", "bit3 reads zero", {28'd0, cfg_rd_data}, 32'h7);
    cfg_write(4'h8);
    chk("R2", "bit3 only write", {28'd0, cfg_rd_data}, 32'h0);
    cfg_write(4'h5);
    chk("R1", "write 5", {28'd0, cfg_rd_data}, 32'h5);
    cfg_write(4'h2);
    chk("R1", "write 2", {28'd0, cfg_rd_data}, 32'h2);
  endtask

  task automatic t_pass;
    cfg_write(4'h4);
    for (int k = 0; k < 5; k++) begin
      send(3'(k), 32'h1234_5600 + 32'(k), 4'hA, 8'h10 + 8'(k));
      expect_out("R3", 3'(k), 32'h1234_5600 + 32'(k), 4'hA, 8'h10 + 8'(k));
      @(negedge clk); #1;
      chk("R3", "no ret on pass", {31'd0, ret_valid}, 32'd0);
    end
  endtask

  task automatic t_redirect_wr;
    logic [2:0] ks[3] = '{3'd1, 3'd3, 3'd4};
    cfg_write(4'h3);
    foreach (ks[i]) begin
      send(ks[i], 32'hFEE0_0000 + 32'(i), 4'hF, 8'h20 + 8'(i));
      expect_out("R4", 3'd1, SINK, 4'h0, 8'h20 + 8'(i));
      @(negedge clk); #1;
      chk("R4", "no ret on write", {31'd0, ret_valid}, 32'd0);
    end
  endtask

  task automatic t_redirect_rd;
    logic [2:0] ks[2] = '{3'd0, 3'd2};
    cfg_write(4'h0);
    foreach (ks[i]) begin
      send(ks[i], 32'h8000_0040, 4'h3, 8'h30 + 8'(i));
      expect_out("R5", 3'd0, SINK, 4'h3, 8'h30 + 8'(i));
      @(negedge clk); #1;
      chk("R5", "ret_valid", {31'd0, ret_valid}, 32'd1);
      chk("R5", "ret_tag", {24'd0, ret_tag}, {24'd0, 8'h30 + 8'(i)});
      chk("R5", "ret_status", {29'd0, ret_status}, 32'd1);
      @(negedge clk); #1;
      chk("R5", "exactly one ret", {31'd0, ret_valid}, 32'd0);
    end
  endtask

  task automatic t_cpl;
    cfg_write(4'h0);
    send(3'd5, 32'h0000_ABCD, 4'h9, 8'h44);
    expect_out("R7", 3'd5, 32'h0000_ABCD, 4'h9, 8'h44);
    @(negedge clk); #1;
    chk("R7", "no ret on cpl", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_ur_order;
    cfg_write(4'h0);
    out_ready = 1'b0;
    send(3'd0, 32'h10, 4'hF, 8'h55);
    chk("R6", "held read valid", {31'd0, out_valid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      chk("R6", "no ret while held", {31'd0, ret_valid}, 32'd0);
      @(negedge clk); #1;
    end
    out_ready = 1'b1;
    @(negedge clk); #1;
    chk("R6", "ret after accept", {31'd0, ret_valid}, 32'd1);
    chk("R6", "out drained", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #1;
  endtask

  task automatic t_sample;
    // write in same cycle as acceptance: old enable (1) applies
    cfg_write(4'h4);
    cfg_wr_en = 1'b1; cfg_wr_data = 4'h0;
    send(3'd1, 32'h2000_0000, 4'hC, 8'h61);
    cfg_wr_en = 1'b0;
    expect_out("R8", 3'd1, 32'h2000_0000, 4'hC, 8'h61);
    chk("R8", "enable now clear", {28'd0, cfg_rd_data}, 32'h0);
    // write while request waits at output
    cfg_write(4'h4);
    out_ready = 1'b0;
    send(3'd1, 32'h2000_0100, 4'h3, 8'h62);
    cfg_write(4'h0);
    expect_out("R8", 3'd1, 32'h2000_0100, 4'h3, 8'h62);
    out_ready = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic t_backpressure;
    cfg_write(4'h4);
    out_ready = 1'b0;
    send(3'd1, 32'hA, 4'h1, 8'h71);
    chk("R9", "in_ready low when full", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_kind = 3'd3; in_addr = 32'hB; in_be = 4'h2; in_tag = 8'h72;
    @(negedge clk); #1;
    @(negedge clk); #1;
    expect_out("R9", 3'd1, 32'hA, 4'h1, 8'h71);
    out_ready = 1'b1; #1;
    chk("R9", "in_ready with out_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0; #1;
    expect_out("R9", 3'd3, 32'hB, 4'h2, 8'h72);
    @(negedge clk); #1;
    chk("R9", "drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_ur_block;
    cfg_write(4'h0);
    ret_ready = 1'b0;
    send(3'd0, 32'h1, 4'hF, 8'h81);
    @(negedge clk); #1;
    chk("R10", "first ret pending", {31'd0, ret_valid}, 32'd1);
    send(3'd2, 32'h2, 4'hF, 8'h82);
    chk("R10", "second read held", {31'd0, out_valid}, 32'd0);
    chk("R10", "first tag kept", {24'd0, ret_tag}, 32'h81);
    ret_ready = 1'b1;
    @(negedge clk); #1;
    chk("R10", "first ret taken", {31'd0, ret_valid}, 32'd0);
    expect_out("R10", 3'd0, SINK, 4'hF, 8'h82);
    @(negedge clk); #1;
    chk("R10", "second ret", {31'd0, ret_valid}, 32'd1);
    chk("R10", "second tag", {24'd0, ret_tag}, 32'h82);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset;
    t_cmd;
    t_pass;
    t_redirect_wr;
    t_redirect_rd;
    t_cpl;
    t_ur_order;
    t_sample;
    t_backpressure;
    t_ur_block;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule